// File: doc/BRIEF.md
# MMU Fault Status Registers

This block records what went wrong when an address translation unit reports a fault. Each time the fault strobe pulses, it captures three things. The first is a packed status word built from the fault's attributes. The second is the page number and context of the access, placed in a tag-access register. The third is the full faulting address, kept in a fault address register; that register exists only when the block is built for the data side. The status word carries a valid bit. It also carries an overwrite bit, which shows that a later fault replaced one that software had not yet cleared.

Software reaches the registers through a small register port. It chooses a register with a 2-bit select and reads it combinationally. Writing zero to a register clears that register. The block does not detect faults or raise traps; the translation logic around it does both.

Top module: `mmu_fault_regs`

## Requirements
- R1: After reset, every register reads zero through the register port.
- R2: A fault that arrives while status bit 0 is clear loads the status word with bit 0 = 1 and bit 1 = 0, plus the attribute fields of that fault.
- R3: A fault that arrives while status bit 0 is set loads the status word with bits 1:0 = 3. The attribute fields are replaced by those of the new fault.
- R4: The status field layout is fixed. Bit 2 is the write flag. Bits 5:4 hold the context type and bit 6 the side-effect flag. Bits 13:7 hold the fault type and bits 23:16 the address space identifier. Bit 3, bits 15:14 and every bit above 23 read zero.
- R5: When DATA_SIDE = 1, a fault latches the full faulting address into the fault address register. When DATA_SIDE = 0, that register always reads zero.
- R6: A fault loads the tag-access register with address bits VA_W-1:13 in bits VA_W-1:13 and the 13-bit context id in bits 12:0.
- R7: A register-port write of zero clears the selected register. A write of any non-zero value has no effect.
- R8: If a fault and a clearing write arrive in the same cycle, the fault is captured and the clear is dropped.
- R9: Select 0 reads the status word, zero-extended. Select 1 reads the fault address. Select 2 reads the tag-access register. Select 3 reads zero.
- R10: With neither a fault nor a clearing write, all registers hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fault_i | input | 1 | Fault strobe, one cycle per fault |
| fault_write_i | input | 1 | The faulting access was a store |
| fault_ctx_type_i | input | 2 | Context type of the access |
| fault_side_eff_i | input | 1 | Side-effect flag of the access |
| fault_type_i | input | 7 | Fault type code |
| fault_asi_i | input | 8 | Address space identifier of the access |
| fault_va_i | input | VA_W | Faulting virtual address |
| fault_ctx_i | input | 13 | Context id of the access |
| reg_sel_i | input | 2 | Register select |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | VA_W | Register write data |
| reg_rdata_o | output | VA_W | Read data of the selected register |

## Verification
The bench builds two copies side by side from the same stimulus. One copy uses DATA_SIDE = 1 and the other DATA_SIDE = 0, so both the latched fault address and the register that always reads zero are checked in the same cycles. Both copies use the default VA_W = 64. That width puts the top address bit and the page/context split at bit 13 within reach with all-ones and random addresses. Back-to-back faults and clears that coincide with faults come up often under random stimulus.

// File: rtl/mmu_fsr_pkg.sv
package mmu_fsr_pkg;
  localparam int unsigned CT_W   = 2;
  localparam int unsigned FT_W   = 7;
  localparam int unsigned ASI_W  = 8;
  localparam int unsigned CTX_W  = 13;
  localparam int unsigned STAT_W = 24;

  // status word bit positions
  localparam int unsigned POS_VLD = 0;
  localparam int unsigned POS_OVW = 1;
  localparam int unsigned POS_WR  = 2;
  localparam int unsigned POS_CT  = 4;
  localparam int unsigned POS_SE  = 6;
  localparam int unsigned POS_FT  = 7;
  localparam int unsigned POS_ASI = 16;

  typedef enum logic [1:0] {
    SEL_STAT = 2'd0,
    SEL_ADDR = 2'd1,
    SEL_TAG  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic             wr;
    logic [CT_W-1:0]  ct;
    logic             se;
    logic [FT_W-1:0]  ft;
    logic [ASI_W-1:0] asi;
  } fault_attr_t;
endpackage

// File: rtl/fsr_status_reg.sv
module fsr_status_reg
  import mmu_fsr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fault_i,
  input  fault_attr_t       attr_i,
  input  logic              clr_i,
  output logic [STAT_W-1:0] stat_o
);
  logic [STAT_W-1:0] stat_q, stat_d;

  always_comb begin
    stat_d = '0;
    stat_d[POS_VLD]               = 1'b1;
    stat_d[POS_OVW]               = stat_q[POS_VLD];
    stat_d[POS_WR]                = attr_i.wr;
    stat_d[POS_CT +: CT_W]        = attr_i.ct;
    stat_d[POS_SE]                = attr_i.se;
    stat_d[POS_FT +: FT_W]        = attr_i.ft;
    stat_d[POS_ASI +: ASI_W]      = attr_i.asi;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      stat_q <= '0;
    else if (fault_i) stat_q <= stat_d;
    else if (clr_i)   stat_q <= '0;
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/fsr_addr_reg.sv
module fsr_addr_reg #(
  parameter int unsigned VA_W = 64,
  parameter bit          EN   = 1'b1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            fault_i,
  input  logic [VA_W-1:0] va_i,
  input  logic            clr_i,
  output logic [VA_W-1:0] addr_o
);
  generate
    if (EN) begin : g_addr
      logic [VA_W-1:0] addr_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      addr_q <= '0;
        else if (fault_i) addr_q <= va_i;
        else if (clr_i)   addr_q <= '0;
      end
      assign addr_o = addr_q;
    end else begin : g_none
      assign addr_o = '0;
    end
  endgenerate
endmodule

// File: rtl/fsr_tag_reg.sv
module fsr_tag_reg
  import mmu_fsr_pkg::*;
#(
  parameter int unsigned VA_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fault_i,
  input  logic [VA_W-1:0]  va_i,
  input  logic [CTX_W-1:0] ctx_i,
  input  logic             clr_i,
  output logic [VA_W-1:0]  tag_o
);
  logic [VA_W-1:0] tag_q;
  logic [VA_W-1:0] tag_d;

  assign tag_d = {va_i[VA_W-1:CTX_W], ctx_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      tag_q <= '0;
    else if (fault_i) tag_q <= tag_d;
    else if (clr_i)   tag_q <= '0;
  end

  assign tag_o = tag_q;
endmodule

// File: rtl/mmu_fault_regs.sv
module mmu_fault_regs
  import mmu_fsr_pkg::*;
#(
  parameter int unsigned VA_W      = 64,
  parameter bit          DATA_SIDE = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fault_i,
  input  logic             fault_write_i,
  input  logic [CT_W-1:0]  fault_ctx_type_i,
  input  logic             fault_side_eff_i,
  input  logic [FT_W-1:0]  fault_type_i,
  input  logic [ASI_W-1:0] fault_asi_i,
  input  logic [VA_W-1:0]  fault_va_i,
  input  logic [CTX_W-1:0] fault_ctx_i,
  input  logic [1:0]       reg_sel_i,
  input  logic             reg_wr_i,
  input  logic [VA_W-1:0]  reg_wdata_i,
  output logic [VA_W-1:0]  reg_rdata_o
);
  localparam int unsigned PAD_W = VA_W - STAT_W;

  fault_attr_t       attr;
  logic              wr_zero;
  logic              clr_stat, clr_addr, clr_tag;
  logic [STAT_W-1:0] stat_q;
  logic [VA_W-1:0]   addr_q, tag_q;

  assign attr = '{wr: fault_write_i, ct: fault_ctx_type_i, se: fault_side_eff_i,
                  ft: fault_type_i, asi: fault_asi_i};

  // only an all-zero write acts
  assign wr_zero  = reg_wr_i && (reg_wdata_i == '0);
  assign clr_stat = wr_zero && (reg_sel_i == SEL_STAT);
  assign clr_addr = wr_zero && (reg_sel_i == SEL_ADDR);
  assign clr_tag  = wr_zero && (reg_sel_i == SEL_TAG);

  fsr_status_reg u_stat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fault_i(fault_i),
    .attr_i (attr),
    .clr_i  (clr_stat),
    .stat_o (stat_q)
  );

  fsr_addr_reg #(.VA_W(VA_W), .EN(DATA_SIDE)) u_addr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fault_i(fault_i),
    .va_i   (fault_va_i),
    .clr_i  (clr_addr),
    .addr_o (addr_q)
  );

  fsr_tag_reg #(.VA_W(VA_W)) u_tag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fault_i(fault_i),
    .va_i   (fault_va_i),
    .ctx_i  (fault_ctx_i),
    .clr_i  (clr_tag),
    .tag_o  (tag_q)
  );

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_sel_i)
      SEL_STAT: reg_rdata_o = {{PAD_W{1'b0}}, stat_q};
      SEL_ADDR: reg_rdata_o = addr_q;
      SEL_TAG:  reg_rdata_o = tag_q;
      default:  reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/mmu_fault_regs_chk.sv
module mmu_fault_regs_chk
  import mmu_fsr_pkg::*;
#(
  parameter int unsigned VA_W      = 64,
  parameter bit          DATA_SIDE = 1'b1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              fault_i,
  input logic              fault_write_i,
  input logic [CT_W-1:0]   fault_ctx_type_i,
  input logic              fault_side_eff_i,
  input logic [FT_W-1:0]   fault_type_i,
  input logic [ASI_W-1:0]  fault_asi_i,
  input logic [VA_W-1:0]   fault_va_i,
  input logic [CTX_W-1:0]  fault_ctx_i,
  input logic [1:0]        reg_sel_i,
  input logic              reg_wr_i,
  input logic [VA_W-1:0]   reg_wdata_i,
  input logic [STAT_W-1:0] stat_q,
  input logic [VA_W-1:0]   addr_q,
  input logic [VA_W-1:0]   tag_q
);
  logic clr_any;
  assign clr_any = reg_wr_i && (reg_wdata_i == '0);

  AST_FIRST_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_i && !stat_q[0]) |=> (stat_q[1:0] == 2'b01)); // R2

  AST_OVERWRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_i && stat_q[0]) |=> (stat_q[1:0] == 2'b11)); // R3

  AST_FIELDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_i |=> (stat_q[2] == $past(fault_write_i)) && (stat_q[5:4] == $past(fault_ctx_type_i))
               && (stat_q[6] == $past(fault_side_eff_i)) && (stat_q[13:7] == $past(fault_type_i))
               && (stat_q[23:16] == $past(fault_asi_i))); // R4

  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q[3] == 1'b0) && (stat_q[15:14] == 2'b00)); // R4

  AST_FAULT_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_i |=> (addr_q == (DATA_SIDE ? $past(fault_va_i) : '0))); // R5

  AST_TAG_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_i |=> (tag_q[VA_W-1:CTX_W] == $past(fault_va_i[VA_W-1:CTX_W]))
               && (tag_q[CTX_W-1:0] == $past(fault_ctx_i))); // R6

  AST_CLEAR_STAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_any && reg_sel_i == 2'd0 && !fault_i) |=> (stat_q == '0)); // R7

  AST_FAULT_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_any && fault_i) |=> stat_q[0]); // R8

  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fault_i && !clr_any) |=> ($stable(stat_q) && $stable(addr_q) && $stable(tag_q))); // R10
endmodule

bind mmu_fault_regs mmu_fault_regs_chk #(.VA_W(VA_W), .DATA_SIDE(DATA_SIDE)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .fault_i         (fault_i),
  .fault_write_i   (fault_write_i),
  .fault_ctx_type_i(fault_ctx_type_i),
  .fault_side_eff_i(fault_side_eff_i),
  .fault_type_i    (fault_type_i),
  .fault_asi_i     (fault_asi_i),
  .fault_va_i      (fault_va_i),
  .fault_ctx_i     (fault_ctx_i),
  .reg_sel_i       (reg_sel_i),
  .reg_wr_i        (reg_wr_i),
  .reg_wdata_i     (reg_wdata_i),
  .stat_q          (stat_q),
  .addr_q          (addr_q),
  .tag_q           (tag_q)
);

// File: tb/sim_mmu_fault_regs.sv
`timescale 1ns/1ps
module sim_mmu_fault_regs;
  localparam int unsigned VA_W = 64;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            f = 1'b0, f_wr = 1'b0, f_se = 1'b0;
  logic [1:0]      f_ct = '0;
  logic [6:0]      f_ft = '0;
  logic [7:0]      f_asi = '0;
  logic [VA_W-1:0] f_va = '0;
  logic [12:0]     f_ctx = '0;
  logic [1:0]      sel = '0;
  logic            wr = 1'b0;
  logic [VA_W-1:0] wdata = '0;
  logic [VA_W-1:0] rd_d, rd_i;

  int checks = 0, errors = 0;
  logic [VA_W-1:0] e_stat = '0, e_addr = '0, e_tag = '0;

  always #4 clk = ~clk;

  mmu_fault_regs #(.VA_W(VA_W), .DATA_SIDE(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .fault_i(f), .fault_write_i(f_wr),
    .fault_ctx_type_i(f_ct), .fault_side_eff_i(f_se), .fault_type_i(f_ft),
    .fault_asi_i(f_asi), .fault_va_i(f_va), .fault_ctx_i(f_ctx),
    .reg_sel_i(sel), .reg_wr_i(wr), .reg_wdata_i(wdata), .reg_rdata_o(rd_d));

  mmu_fault_regs #(.VA_W(VA_W), .DATA_SIDE(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .fault_i(f), .fault_write_i(f_wr),
    .fault_ctx_type_i(f_ct), .fault_side_eff_i(f_se), .fault_type_i(f_ft),
    .fault_asi_i(f_asi), .fault_va_i(f_va), .fault_ctx_i(f_ctx),
    .reg_sel_i(sel), .reg_wr_i(wr), .reg_wdata_i(wdata), .reg_rdata_o(rd_i));

  function automatic logic [VA_W-1:0] pack_stat(logic [VA_W-1:0] old, logic w,
      logic [1:0] ct, logic se, logic [6:0] ft, logic [7:0] asi);
    logic [VA_W-1:0] s = '0;
    s[1:0]   = old[0] ? 2'b11 : 2'b01;
    s[2]     = w;
    s[5:4]   = ct;
    s[6]     = se;
    s[13:7]  = ft;
    s[23:16] = asi;
    return s;
  endfunction

  task automatic chk(string req, string what, logic [VA_W-1:0] act, logic [VA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // read every select on both copies
  task automatic check_all(string req);
    for (int s = 0; s < 4; s++) begin
      sel = s[1:0];
      #0.1;
      case (s)
        0: begin chk(req, "stat d", rd_d, e_stat); chk(req, "stat i", rd_i, e_stat); end
        1: begin chk(req, "addr d", rd_d, e_addr); chk(req, "addr i (R5)", rd_i, '0); end
        2: begin chk(req, "tag d", rd_d, e_tag);   chk(req, "tag i", rd_i, e_tag); end
        default: begin chk(req, "sel3 d (R9)", rd_d, '0); chk(req, "sel3 i (R9)", rd_i, '0); end
      endcase
    end
  endtask

  // inputs are already driven; clock one edge, update the model, check
  task automatic tick(string req);
    @(posedge clk);
    if (f) begin
      e_stat = pack_stat(e_stat, f_wr, f_ct, f_se, f_ft, f_asi);
      e_addr = f_va;
      e_tag  = {f_va[VA_W-1:13], f_ctx};
    end else if (wr && wdata == '0) begin
      case (sel)
        2'd0: e_stat = '0;
        2'd1: e_addr = '0;
        2'd2: e_tag  = '0;
        default: ;
      endcase
    end
    #1;
    f = 1'b0; wr = 1'b0; wdata = '0;
    check_all(req);
  endtask

  task automatic set_fault(logic w, logic [1:0] ct, logic se, logic [6:0] ft,
      logic [7:0] asi, logic [VA_W-1:0] va, logic [12:0] ctx);
    f = 1'b1; f_wr = w; f_ct = ct; f_se = se; f_ft = ft; f_asi = asi; f_va = va; f_ctx = ctx;
  endtask

  initial begin
    #1600000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    #20 rst_n = 1'b1;
    #3;
    check_all("R1");

    // first fault, all fields distinct
    set_fault(1'b1, 2'd2, 1'b0, 7'h55, 8'hA3, 64'h1234_5678_9ABC_DEF0, 13'h1ABC);
    tick("R2");
    sel = 2'd0; #0.1; chk("R2", "ovw clear", {63'd0, rd_d[1]}, '0);

    // second fault before clear
    set_fault(1'b0, 2'd1, 1'b1, 7'h2A, 8'h5C, {64{1'b1}}, 13'h1FFF);
    tick("R3");
    sel = 2'd0; #0.1; chk("R3", "vld+ovw", {62'd0, rd_d[1:0]}, 64'd3);

    // all-ones attributes: field positions and reserved bits
    set_fault(1'b1, 2'd3, 1'b1, 7'h7F, 8'hFF, 64'h8000_0000_0000_1FFF, 13'h0);
    tick("R4");
    sel = 2'd0; #0.1; chk("R4", "stat pattern", rd_d, 64'h00FF_3FF7);

    // tag split at bit 13
    sel = 2'd2; #0.1; chk("R6", "tag split", rd_d, 64'h8000_0000_0000_0000);

    // non-zero writes ignored
    for (int s = 0; s < 3; s++) begin
      sel = s[1:0]; wr = 1'b1; wdata = 64'h1;
      tick("R7");
    end
    // zero writes clear each register
    for (int s = 0; s < 3; s++) begin
      sel = s[1:0]; wr = 1'b1; wdata = '0;
      tick("R7");
    end
    sel = 2'd3; #0.1; chk("R9", "sel3 empty", rd_d, '0);

    // clear and fault together: fault wins
    set_fault(1'b0, 2'd0, 1'b0, 7'h01, 8'h04, 64'hDEAD_0000_BEEF_2000, 13'h0042);
    tick("R2");
    set_fault(1'b1, 2'd2, 1'b1, 7'h11, 8'h80, 64'h0000_0000_0000_4000, 13'h0007);
    sel = 2'd0; wr = 1'b1; wdata = '0;
    tick("R8");
    sel = 2'd0; #0.1; chk("R8", "fault kept", {62'd0, rd_d[1:0]}, 64'd3);

    // idle cycles hold
    for (int i = 0; i < 3; i++) tick("R10");

    // random mix
    for (int i = 0; i < 600; i++) begin
      int unsigned r = $urandom % 8;
      if (r < 3)
        set_fault($urandom % 2 == 1, 2'($urandom), $urandom % 2 == 1, 7'($urandom),
                  8'($urandom), {32'($urandom), 32'($urandom)}, 13'($urandom));
      if (r >= 2 && r < 6) begin
        sel = 2'($urandom); wr = 1'b1;
        wdata = ($urandom % 2 == 1) ? '0 : {32'($urandom), 32'($urandom | 1)};
      end
      tick("R10");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule